// File: doc/BRIEF.md
# CSR Read-Modify-Write Sequencer

This block runs control/status-register instructions in a small execution stage. General registers and CSRs sit in one 6-bit address space and share a single write port. When a decoded CSR instruction arrives, the block receives these values:

- an operand from the source register
- the CSR value as read before the instruction
- the CSR address
- the destination register
- a 2-bit operation code

The sequencer then makes two writes through the shared port on consecutive cycles. The first returns the old CSR value to the destination register. The second stores the updated value at the CSR address. One cycle after that it pulses a completion flag.

The update rule depends on the operation code: a plain write, a bit-set or a bit-clear. The fourth code is illegal. For it the sequencer issues no writes and no completion; it raises an error pulse instead.

Top module: `csr_rmw_seq`

## Requirements
- R1: While reset is high and in the cycle after, `wr_en`, `done`, `bad_op` and `busy` are all 0.
- R2: An accepted legal `start` in an idle cycle gives `wr_en`=1 in the next cycle, with `wr_addr`=`dest_addr` and `wr_data`=`csr_old` as sampled at acceptance.
- R3: In the cycle after the first write, `wr_en`=1, `wr_addr`=`csr_addr` and `wr_data` is the updated CSR value, both taken at acceptance.
- R4: Op code 2'b00 (write) gives an updated value equal to `opnd`.
- R5: Op code 2'b01 (set) gives an updated value equal to `opnd | csr_old`.
- R6: Op code 2'b10 (clear) gives an updated value equal to `csr_old & ~opnd`.
- R7: `done` is 1 for exactly the one cycle after the second write, with `wr_en`=0. Each legal instruction makes exactly two writes.
- R8: Op code 2'b11 is illegal. `bad_op` pulses for the one cycle after acceptance, with no write and no `done`.
- R9: `start` is ignored while `busy`=1. Input changes after acceptance do not alter the writes in progress.
- R10: When `dest_addr` is 0, the first write is still issued, with `wr_addr`=0.
- R11: `busy` is 1 from the cycle after acceptance through the `done` (or `bad_op`) cycle, and 0 in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Decoded CSR instruction present |
| op | input | 2 | Operation code: 00 write, 01 set, 10 clear, 11 illegal |
| opnd | input | 32 | Source operand |
| csr_old | input | 32 | CSR value before the instruction |
| csr_addr | input | 6 | CSR address in the shared space |
| dest_addr | input | 6 | Destination register address |
| busy | output | 1 | Sequencer not idle |
| wr_en | output | 1 | Shared write port enable |
| wr_addr | output | 6 | Shared write port address |
| wr_data | output | 32 | Shared write port data |
| done | output | 1 | Instruction complete pulse |
| bad_op | output | 1 | Illegal operation pulse |

## Verification
Two functions can fall in the same cycle: a fresh `start` can arrive while the sequencer is still writing or is pulsing `done`. The bench provokes this by holding `start` high and changing every operand and address through the whole sequence. It then checks that both writes still carry the values captured at acceptance and that no third write appears before idle. It also checks that `busy` drops in the cycle after `done`, which is the first cycle in which a new instruction can be taken.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

  typedef enum logic [1:0] {
    OPK_WRITE = 2'b00,
    OPK_SET   = 2'b01,
    OPK_CLEAR = 2'b10,
    OPK_BAD   = 2'b11
  } opk_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WR_DEST,
    SQ_WR_CSR,
    SQ_FINISH,
    SQ_FAULT
  } sq_state_e;

  function automatic logic op_is_legal(input logic [1:0] code);
    return code != OPK_BAD;
  endfunction

endpackage

// File: rtl/csr_rmw_update.sv
module csr_rmw_update #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] opnd,
  input  logic [DATA_W-1:0] old_val,
  output logic [DATA_W-1:0] new_val
);
  import csr_rmw_pkg::*;

  always_comb begin
    case (op)
      OPK_WRITE: new_val = opnd;
      OPK_SET:   new_val = old_val | opnd;
      OPK_CLEAR: new_val = old_val & ~opnd;
      default:   new_val = old_val;
    endcase
  end

endmodule

// File: rtl/csr_rmw_ctrl.sv
module csr_rmw_ctrl #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] csr_old,
  input  logic [DATA_W-1:0] new_val,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [ADDR_W-1:0] dest_addr,
  output logic              busy,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              done,
  output logic              bad_op
);
  import csr_rmw_pkg::*;

  sq_state_e         state;
  logic [ADDR_W-1:0] held_addr;
  logic [DATA_W-1:0] held_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      done      <= 1'b0;
      bad_op    <= 1'b0;
      held_addr <= '0;
      held_val  <= '0;
    end else begin
      wr_en  <= 1'b0;
      done   <= 1'b0;
      bad_op <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (start) begin
            if (op_is_legal(op)) begin
              state     <= SQ_WR_DEST;
              wr_en     <= 1'b1;
              wr_addr   <= dest_addr;
              wr_data   <= csr_old;
              held_addr <= csr_addr;
              held_val  <= new_val;
            end else begin
              state  <= SQ_FAULT;
              bad_op <= 1'b1;
            end
          end
        end
        SQ_WR_DEST: begin
          state   <= SQ_WR_CSR;
          wr_en   <= 1'b1;
          wr_addr <= held_addr;
          wr_data <= held_val;
        end
        SQ_WR_CSR: begin
          state <= SQ_FINISH;
          done  <= 1'b1;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign busy = (state != SQ_IDLE);

  // R2
  first_write_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op_is_legal(op)) |=>
      (wr_en && wr_addr == $past(dest_addr) && wr_data == $past(csr_old)));

  // R3
  second_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(csr_addr, 2)));

  // R7
  done_after_pair_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!wr_en && $past(wr_en) && $past(wr_en, 2)));

  // R8
  bad_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    bad_op |-> (!wr_en && !done));

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> !(wr_en && !$past(wr_en)));

  // R11
  busy_release_chk: assert property (@(posedge clk) disable iff (rst)
    (done || bad_op) |=> !busy);

endmodule

// File: rtl/csr_rmw_seq.sv
module csr_rmw_seq #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] opnd,
  input  logic [DATA_W-1:0] csr_old,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [ADDR_W-1:0] dest_addr,
  output logic              busy,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              done,
  output logic              bad_op
);

  logic [DATA_W-1:0] upd_val;

  csr_rmw_update #(.DATA_W(DATA_W)) upd_i (
    .op      (op),
    .opnd    (opnd),
    .old_val (csr_old),
    .new_val (upd_val)
  );

  csr_rmw_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .op        (op),
    .csr_old   (csr_old),
    .new_val   (upd_val),
    .csr_addr  (csr_addr),
    .dest_addr (dest_addr),
    .busy      (busy),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .done      (done),
    .bad_op    (bad_op)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!wr_en && !done && !bad_op && !busy));

endmodule

// File: tb/csr_rmw_seq_tb_top.sv
module csr_rmw_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] opnd = '0;
  logic [31:0] csr_old = '0;
  logic [5:0]  csr_addr = '0;
  logic [5:0]  dest_addr = '0;
  logic        busy, wr_en, done, bad_op;
  logic [5:0]  wr_addr;
  logic [31:0] wr_data;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  csr_rmw_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .op(op), .opnd(opnd),
    .csr_old(csr_old), .csr_addr(csr_addr), .dest_addr(dest_addr),
    .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .bad_op(bad_op)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [1:0] c,
                                       input logic [31:0] a,
                                       input logic [31:0] o);
    case (c)
      2'b00:   return a;
      2'b01:   return a | o;
      default: return o & ~a;
    endcase
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check({wr_en, done, bad_op, busy} == 4'b0, "R1 in reset",
          {28'b0, wr_en, done, bad_op, busy}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check({wr_en, done, bad_op, busy} == 4'b0, "R1 after reset",
          {28'b0, wr_en, done, bad_op, busy}, 32'h0);
  endtask

  // Runs one legal instruction; with hold set, start stays high and all
  // inputs change during the sequence (R9).
  task automatic run_legal(input logic [1:0] c, input logic [31:0] a,
                           input logic [31:0] o, input logic [5:0] ca,
                           input logic [5:0] da, input bit hold,
                           input string tag);
    logic [31:0] exp_new;
    exp_new = model(c, a, o);
    op = c; opnd = a; csr_old = o; csr_addr = ca; dest_addr = da;
    start = 1'b1;
    @(negedge clk);
    if (hold) begin
      op = c ^ 2'b01; opnd = ~a; csr_old = ~o; csr_addr = ~ca; dest_addr = ~da;
    end else begin
      start = 1'b0;
    end
    check(wr_en && wr_addr == da && wr_data == o && busy,
          {"R2 first write ", tag}, {wr_en, busy, wr_addr, wr_data[23:0]},
          {2'b11, da, o[23:0]});
    @(negedge clk);
    check(wr_en && wr_addr == ca, {"R3 second write addr ", tag},
          {25'b0, wr_en, wr_addr}, {25'b0, 1'b1, ca});
    check(wr_data == exp_new, {"R4/R5/R6 update value ", tag}, wr_data, exp_new);
    check(!done, {"R7 no early done ", tag}, {31'b0, done}, 32'h0);
    @(negedge clk);
    check(done && !wr_en && busy, {"R7 done pulse ", tag},
          {29'b0, done, wr_en, busy}, 32'h5);
    @(negedge clk);
    check(!done && !wr_en && !busy, {"R11 idle after done ", tag},
          {29'b0, done, wr_en, busy}, 32'h0);
    start = 1'b0;
    @(negedge clk);
    check(!wr_en, {"R9 no extra write ", tag}, {31'b0, wr_en}, 32'h0);
  endtask

  task automatic test_illegal();
    op = 2'b11; opnd = 32'hFFFF_0000; csr_old = 32'h1234_5678;
    csr_addr = 6'd40; dest_addr = 6'd3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(bad_op && !wr_en && !done && busy, "R8 bad_op pulse",
          {28'b0, bad_op, wr_en, done, busy}, 32'h9);
    @(negedge clk);
    check(!bad_op && !wr_en && !done && !busy, "R8 quiet after bad_op",
          {28'b0, bad_op, wr_en, done, busy}, 32'h0);
  endtask

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    test_reset();
    run_legal(2'b00, 32'hDEAD_BEEF, 32'h0000_00FF, 6'd33, 6'd5, 1'b0, "R4 write");
    run_legal(2'b01, 32'h0F0F_0000, 32'h0000_F0F0, 6'd48, 6'd12, 1'b0, "R5 set");
    run_legal(2'b10, 32'hFF00_00FF, 32'hF0F0_F0F0, 6'd63, 6'd31, 1'b0, "R6 clear");
    run_legal(2'b10, 32'hFFFF_FFFF, 32'h8000_0001, 6'd34, 6'd1, 1'b0, "R6 clear all");
    run_legal(2'b01, 32'h0000_0001, 32'hAAAA_AAAA, 6'd35, 6'd0, 1'b0, "R10 x0 dest");
    run_legal(2'b00, 32'h5555_5555, 32'h0000_0000, 6'd36, 6'd7, 1'b1, "R9 held start");
    test_illegal();
    run_legal(2'b01, 32'h0000_0100, 32'h0000_0010, 6'd37, 6'd9, 1'b0, "R11 after fault");
    finish_run();
  end

endmodule